// File: doc/BRIEF.md
# Fully Associative Translation Cache with Access Protection

This block holds recently used virtual-to-physical page translations and answers a lookup in one clock cycle. A request carries a 32-bit virtual address, a flag saying whether the access is a write, and a flag saying whether the requester runs in kernel mode. The upper 20 bits (the virtual page number) are compared against every stored entry at once. One cycle after the request, the block reports exactly one outcome:
- a hit, with the physical address formed from the stored physical page number and the unchanged 12-bit offset;
- a miss;
- a protection fault.

A page walker outside the block answers misses. It installs translations through a fill port. A new page number goes into the slot named by a first-in first-out pointer. A page number that is already present is rewritten in its own slot. A flush input drops every translation in one cycle.

Top module: `xlat_cache`

## Requirements
- R1: After synchronous reset, `rsp_valid`, `rsp_hit`, `rsp_miss` and `rsp_fault` are 0, and every lookup misses until a fill is made.
- R2: A lookup whose page number matches a valid entry and passes the access checks gives `rsp_hit`=1 one cycle after the request. In the same cycle, `rsp_paddr` = {stored physical page number, `req_vaddr[11:0]`}.
- R3: A lookup whose page number (`req_vaddr[31:12]`) matches no valid entry gives `rsp_miss`=1 one cycle later.
- R4: A matching lookup raises `rsp_fault` in three cases: a read (`req_write`=0) to an entry with its read bit clear; a write (`req_write`=1) to an entry with its write bit clear; a user-mode access (`req_kernel`=0) to an entry with its user bit clear. Kernel mode ignores the user bit.
- R5: A permitted write that matches an entry whose dirty bit is clear reports `rsp_miss` and not `rsp_hit`.
- R6: Fills of page numbers not already present go into slots 0, 1, … in order and wrap after the last slot. When the cache is full, each new fill evicts the oldest translation.
- R7: A fill whose page number is already present overwrites that entry and does not move the replacement pointer. No two valid entries ever hold the same page number.
- R8: A flush invalidates every entry in one cycle and returns the replacement pointer to slot 0.
- R9: `rsp_valid` equals `req_valid` one cycle earlier. At most one of hit, miss and fault is set, and none of them is set when `rsp_valid` is 0.
- R10: A fill that arrives in the same cycle as a flush is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all translations |
| req_valid | input | 1 | Lookup request |
| req_vaddr | input | 32 | Virtual address of the lookup |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_kernel | input | 1 | 1 = kernel mode, 0 = user mode |
| rsp_valid | output | 1 | Response present (one cycle after request) |
| rsp_hit | output | 1 | Translation found and permitted |
| rsp_miss | output | 1 | No usable translation; walker must refill |
| rsp_fault | output | 1 | Access denied by permission bits |
| rsp_paddr | output | 32 | Physical address on a hit, else 0 |
| fill_valid | input | 1 | Install a translation |
| fill_vpn | input | 20 | Virtual page number to install |
| fill_ppn | input | 20 | Physical page number to install |
| fill_rd | input | 1 | Read permitted |
| fill_wr | input | 1 | Write permitted |
| fill_dirty | input | 1 | Page already marked dirty |
| fill_user | input | 1 | Page reachable from user mode |

## Verification
The bench fills all 32 slots, each with a different permission pattern, then sweeps every entry through both access types and both modes. A wrong priority between a fault and the dirty-bit miss, or a user-bit check that ignores kernel mode, shows up as the wrong outcome flag. It refreshes a present page number and then fills a new one. A design that duplicates the entry, or that advances the pointer on the refresh, evicts the wrong victim. It flushes after partial fills and then fills a full wrap: a design whose pointer survives the flush evicts a slot other than 0. It also applies a fill in the same cycle as a flush, and a design that lets the fill through leaves a stray hit.

// File: rtl/xlat_pkg.sv
`timescale 1ns/1ps
package xlat_pkg;
  typedef struct packed {
    logic rd;
    logic wr;
    logic dirty;
    logic user;
  } perm_t;
endpackage

// File: rtl/xlat_cam.sv
`timescale 1ns/1ps
module xlat_cam
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clear,
  input  logic [VPN_W-1:0]   lk_vpn,
  output logic [ENTRIES-1:0] lk_match,
  output logic [PPN_W-1:0]   lk_ppn,
  output perm_t              lk_perm,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [VPN_W-1:0]   wr_vpn,
  input  logic [PPN_W-1:0]   wr_ppn,
  input  perm_t              wr_perm,
  output logic [ENTRIES-1:0] wr_match
);
  logic [ENTRIES-1:0] live_q;
  logic [VPN_W-1:0]   tag_q  [ENTRIES];
  logic [PPN_W-1:0]   ppn_q  [ENTRIES];
  perm_t              perm_q [ENTRIES];

  always_ff @(posedge clk) begin
    if (rst || clear) live_q <= '0;
    else if (wr_en)   live_q[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]  <= wr_vpn;
      ppn_q[wr_idx]  <= wr_ppn;
      perm_q[wr_idx] <= wr_perm;
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign lk_match[g] = live_q[g] && (tag_q[g] == lk_vpn);
    assign wr_match[g] = live_q[g] && (tag_q[g] == wr_vpn);
  end

  always_comb begin
    lk_ppn  = '0;
    lk_perm = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_match[i]) begin
        lk_ppn  = lk_ppn | ppn_q[i];
        lk_perm = lk_perm | perm_q[i];
      end
    end
  end

  AST_MATCH_UNIQUE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lk_match)); // R7
  AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (rst)
    clear |=> (live_q == '0)); // R8
endmodule

// File: rtl/xlat_victim.sv
`timescale 1ns/1ps
module xlat_victim #(
  parameter int ENTRIES = 32,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             advance,
  output logic [IDX_W-1:0] ptr
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  always_ff @(posedge clk) begin
    if (rst || clear)  ptr <= '0;
    else if (advance)  ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
  end

  AST_PTR_HOME: assert property (@(posedge clk) disable iff (rst)
    clear |=> (ptr == '0)); // R8
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!clear && !advance) |=> $stable(ptr)); // R7
endmodule

// File: rtl/xlat_perm.sv
`timescale 1ns/1ps
module xlat_perm
  import xlat_pkg::*;
(
  input  perm_t perm,
  input  logic  is_write,
  input  logic  is_kernel,
  output logic  deny,
  output logic  need_dirty
);
  logic mode_bad, kind_bad;
  always_comb begin
    mode_bad   = !is_kernel && !perm.user;
    kind_bad   = is_write ? !perm.wr : !perm.rd;
    deny       = mode_bad || kind_bad;
    need_dirty = is_write && !perm.dirty;
  end
endmodule

// File: rtl/xlat_cache.sv
`timescale 1ns/1ps
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int OFF_W   = 12,
  localparam int VPN_W  = VA_W - OFF_W,
  localparam int PPN_W  = PA_W - OFF_W,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic             req_write,
  input  logic             req_kernel,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic             rsp_miss,
  output logic             rsp_fault,
  output logic [PA_W-1:0]  rsp_paddr,
  input  logic             fill_valid,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             fill_rd,
  input  logic             fill_wr,
  input  logic             fill_dirty,
  input  logic             fill_user
);
  logic [ENTRIES-1:0] lk_match, fill_match;
  logic [PPN_W-1:0]   lk_ppn;
  perm_t              lk_perm, fill_perm;
  logic [IDX_W-1:0]   victim, same_idx, wr_idx;
  logic               fill_present, wr_en, lk_any, deny, need_dirty;
  logic               nx_hit, nx_miss, nx_fault;

  assign fill_perm = '{rd: fill_rd, wr: fill_wr, dirty: fill_dirty, user: fill_user};

  always_comb begin
    same_idx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (fill_match[i]) same_idx = same_idx | IDX_W'(i);
  end

  assign fill_present = |fill_match;
  assign wr_en        = fill_valid && !flush;
  assign wr_idx       = fill_present ? same_idx : victim;

  xlat_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .IDX_W(IDX_W)) u_cam (
    .clk(clk), .rst(rst), .clear(flush),
    .lk_vpn(req_vaddr[VA_W-1:OFF_W]), .lk_match(lk_match),
    .lk_ppn(lk_ppn), .lk_perm(lk_perm),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn(fill_vpn),
    .wr_ppn(fill_ppn), .wr_perm(fill_perm), .wr_match(fill_match)
  );

  xlat_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
    .clk(clk), .rst(rst), .clear(flush),
    .advance(wr_en && !fill_present), .ptr(victim)
  );

  xlat_perm u_perm (
    .perm(lk_perm), .is_write(req_write), .is_kernel(req_kernel),
    .deny(deny), .need_dirty(need_dirty)
  );

  assign lk_any   = |lk_match;
  assign nx_fault = req_valid && lk_any && deny;
  assign nx_hit   = req_valid && lk_any && !deny && !need_dirty;
  assign nx_miss  = req_valid && !nx_fault && !nx_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_hit   <= nx_hit;
      rsp_miss  <= nx_miss;
      rsp_fault <= nx_fault;
      rsp_paddr <= nx_hit ? {lk_ppn, req_vaddr[OFF_W-1:0]} : '0;
    end
  end

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rsp_hit, rsp_miss, rsp_fault})); // R9
  AST_RSP_TRACKS_REQ: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid); // R9
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> !(rsp_hit || rsp_miss || rsp_fault)); // R9
  AST_HIT_OFFSET: assert property (@(posedge clk) disable iff (rst)
    (req_valid && lk_any && !deny && !need_dirty) |=>
      (rsp_hit && rsp_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0]))); // R2
  AST_REFRESH_NO_MOVE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && fill_present) |=> $stable(victim)); // R7
endmodule

// File: tb/xlat_cache_bench.sv
`timescale 1ns/1ps
module xlat_cache_bench;
  localparam int N = 32;

  logic clk = 1'b0, rst = 1'b1, flush = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_kernel = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic rsp_valid, rsp_hit, rsp_miss, rsp_fault;
  logic [31:0] rsp_paddr;
  logic fill_valid = 1'b0, fill_rd = 1'b0, fill_wr = 1'b0, fill_dirty = 1'b0, fill_user = 1'b0;
  logic [19:0] fill_vpn = '0, fill_ppn = '0;

  int errors = 0, checks = 0;

  // reference model
  logic        m_live [N];
  logic [19:0] m_tag  [N];
  logic [19:0] m_ppn  [N];
  logic [3:0]  m_perm [N]; // {rd, wr, dirty, user}
  int          m_ptr;

  always #10 clk = ~clk;

  xlat_cache u_xlat_cache (
    .clk(clk), .rst(rst), .flush(flush),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_write(req_write), .req_kernel(req_kernel),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_fault(rsp_fault),
    .rsp_paddr(rsp_paddr),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
    .fill_rd(fill_rd), .fill_wr(fill_wr), .fill_dirty(fill_dirty), .fill_user(fill_user)
  );

  task automatic chk(input string rq, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < N; i++) m_live[i] = 1'b0;
    m_ptr = 0;
  endtask

  task automatic do_fill(input logic [19:0] vpn, input logic [19:0] ppn, input logic [3:0] p);
    int slot;
    slot = -1;
    for (int i = 0; i < N; i++) if (m_live[i] && m_tag[i] == vpn) slot = i;
    if (slot < 0) begin slot = m_ptr; m_ptr = (m_ptr + 1) % N; end
    m_live[slot] = 1'b1; m_tag[slot] = vpn; m_ppn[slot] = ppn; m_perm[slot] = p;
    fill_valid = 1'b1; fill_vpn = vpn; fill_ppn = ppn;
    {fill_rd, fill_wr, fill_dirty, fill_user} = p;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic do_flush(input logic with_fill, input logic [19:0] vpn);
    flush = 1'b1;
    fill_valid = with_fill; fill_vpn = vpn; fill_ppn = 20'hABCDE;
    {fill_rd, fill_wr, fill_dirty, fill_user} = 4'b1111;
    @(negedge clk);
    flush = 1'b0; fill_valid = 1'b0;
    model_clear();
  endtask

  task automatic do_lookup(input logic [31:0] va, input logic wr, input logic kern, input string rq);
    int slot;
    logic e_hit, e_miss, e_fault;
    logic [31:0] e_pa;
    logic [3:0] p;
    slot = -1;
    for (int i = 0; i < N; i++) if (m_live[i] && m_tag[i] == va[31:12]) slot = i;
    e_hit = 1'b0; e_miss = 1'b0; e_fault = 1'b0; e_pa = '0;
    if (slot < 0) e_miss = 1'b1;
    else begin
      p = m_perm[slot];
      if ((!kern && !p[0]) || (wr ? !p[2] : !p[3])) e_fault = 1'b1;
      else if (wr && !p[1]) e_miss = 1'b1;
      else begin e_hit = 1'b1; e_pa = {m_ppn[slot], va[11:0]}; end
    end
    req_valid = 1'b1; req_vaddr = va; req_write = wr; req_kernel = kern;
    @(negedge clk);
    chk(rq, "rsp_valid", rsp_valid, 1);
    chk(rq, "hit/miss/fault", {rsp_hit, rsp_miss, rsp_fault}, {e_hit, e_miss, e_fault});
    chk(rq, "rsp_paddr", rsp_paddr, e_pa);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1", "rsp_valid after reset", rsp_valid, 0);
    chk("R1", "outcomes after reset", {rsp_hit, rsp_miss, rsp_fault}, 0);
    do_lookup(32'h0010_0123, 1'b0, 1'b1, "R1");
    do_lookup(32'h0000_0000, 1'b0, 1'b0, "R3");

    // fill every slot with a distinct permission pattern
    for (int i = 0; i < N; i++)
      do_fill(20'h00100 + 20'(i), 20'h50000 + 20'(7 * i), 4'(i % 16));
    // full sweep: R2 hits, R4 faults, R5 dirty misses
    for (int i = 0; i < N; i++)
      for (int k = 0; k < 4; k++)
        do_lookup({20'h00100 + 20'(i), 12'((i * 37 + k * 911) % 4096)},
                  k[0], k[1], "R2/R4/R5");
    // explicit R4: kernel reaches a non-user page, user does not (pattern 4'b1110)
    do_lookup({20'h0010E, 12'h044}, 1'b0, 1'b1, "R4");
    do_lookup({20'h0010E, 12'h044}, 1'b0, 1'b0, "R4");
    // explicit R5: pattern 4'b1101 -> rd, wr, not dirty, user
    do_lookup({20'h0010D, 12'hFFF}, 1'b1, 1'b0, "R5");
    do_lookup({20'h0010D, 12'hFFF}, 1'b0, 1'b0, "R5");
    do_lookup(32'h0777_7000, 1'b0, 1'b1, "R3");

    // R9 idle cycle
    @(negedge clk);
    chk("R9", "rsp_valid idle", rsp_valid, 0);
    chk("R9", "outcomes idle", {rsp_hit, rsp_miss, rsp_fault}, 0);

    // R7 refresh in place, pointer stays at slot 0 (wrapped)
    do_fill(20'h00105, 20'h12345, 4'b1111);
    do_lookup({20'h00105, 12'h9A0}, 1'b1, 1'b0, "R7");
    do_fill(20'h00200, 20'h22222, 4'b1111);
    do_lookup({20'h00100, 12'h001}, 1'b0, 1'b1, "R6"); // evicted
    do_lookup({20'h00101, 12'h001}, 1'b0, 1'b1, "R6"); // kept
    do_lookup({20'h00200, 12'h5A5}, 1'b1, 1'b1, "R6");
    do_lookup({20'h00105, 12'h010}, 1'b0, 1'b1, "R7");

    // R10 fill during flush is dropped; R8 everything gone
    do_flush(1'b1, 20'h00300);
    do_lookup({20'h00300, 12'h000}, 1'b0, 1'b1, "R10");
    do_lookup({20'h00101, 12'h000}, 1'b0, 1'b1, "R8");
    do_lookup({20'h00200, 12'h000}, 1'b0, 1'b1, "R8");

    // R8 pointer returns to 0: advance it, flush, refill a full wrap
    for (int i = 0; i < 3; i++) do_fill(20'h00900 + 20'(i), 20'h1, 4'b1111);
    do_flush(1'b0, 20'h0);
    for (int i = 0; i < N; i++) do_fill(20'h00400 + 20'(i), 20'h60000 + 20'(i), 4'b1111);
    do_fill(20'h00500, 20'h7FFFF, 4'b1111);
    do_lookup({20'h00400, 12'h321}, 1'b0, 1'b0, "R8");
    do_lookup({20'h00401, 12'h321}, 1'b0, 1'b0, "R8");
    do_lookup({20'h00403, 12'h321}, 1'b0, 1'b0, "R8");
    do_lookup({20'h00500, 12'hFED}, 1'b1, 1'b0, "R6");
    for (int i = 2; i < N; i++)
      do_lookup({20'h00400 + 20'(i), 12'(i * 129)}, 1'(i % 2), 1'b0, "R6");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule